// File: doc/BRIEF.md
# Two-Input Table-Driven Four-State Sequencer

This block is a Moore state machine with four states. On each rising clock edge it takes a two-bit selector and moves to a new state. The move is set by a fixed, irregular four-by-four transition table. It is not a count in either direction.

A one-bit flag is decoded from the state alone. A change on the selector therefore never reaches the flag in the same cycle. The current state is also brought out on a two-bit port so that it can be observed.

The state register is a pair of D flip-flops with a synchronous active-high reset. By default the next-state inputs of the two flip-flops are written as explicit sum-of-products equations. A parameter can swap these for an equivalent case table, which is useful for cross-checking.

The states and their codes are:

| State | Code |
|-------|------|
| ST_A | 00 |
| ST_B | 01 |
| ST_C | 10 |
| ST_D | 11 |

The transitions are listed as selector value → next state:

| From | sel 00 | sel 01 | sel 10 | sel 11 |
|------|--------|--------|--------|--------|
| ST_A | ST_A | ST_B | ST_C | ST_D |
| ST_B | ST_A | ST_D | ST_B | ST_D |
| ST_C | ST_B | ST_D | ST_C | ST_A |
| ST_D | ST_B | ST_A | ST_A | ST_D |

Top module: `quad_seq`

## Requirements
- R1: On a rising edge with `rst` high, the state becomes ST_A. This shows on `state_o` as 00, with `flag_o` at 1.
- R2: From ST_A (00), selector values 00, 01, 10 and 11 lead to ST_A, ST_B, ST_C and ST_D respectively.
- R3: From ST_B (01), selector 00 leads to ST_A, 01 to ST_D, 10 holds ST_B, and 11 leads to ST_D.
- R4: From ST_C (10), selector 00 leads to ST_B, 01 to ST_D, 10 holds ST_C, and 11 leads to ST_A.
- R5: From ST_D (11), selector 00 leads to ST_B, 01 to ST_A, 10 to ST_A, and 11 holds ST_D.
- R6: `flag_o` is 1 whenever the state is ST_A (00) or ST_C (10), and 0 whenever it is ST_B (01) or ST_D (11). It depends on the state only.
- R7: While `rst` stays high, the selector has no effect: the state remains ST_A for every selector value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Selector that picks the transition |
| flag_o | output | 1 | Moore output decoded from the state |
| state_o | output | 2 | Current state code |

## Verification
A selector value applied before a rising edge shows on `state_o` just after that edge, one register stage later. `flag_o` changes in that same cycle, because it is a pure decode of the registered state. The bench drives inputs on the falling edge and samples half a period after the rising edge, so every check looks at exactly one transition.

Every one of the sixteen state/selector pairs is reached in the same way. The bench resets, steps from ST_A into the wanted state, and then applies the selector under test.

// File: rtl/quad_seq_pkg.sv
package quad_seq_pkg;

    localparam int SEL_W = 2;
    localparam int ST_W  = 2;

    typedef enum logic [ST_W-1:0] {
        ST_A = 2'b00,
        ST_B = 2'b01,
        ST_C = 2'b10,
        ST_D = 2'b11
    } qs_state_e;

endpackage

// File: rtl/quad_seq_next.sv
module quad_seq_next
    import quad_seq_pkg::*;
#(
    parameter bit USE_SOP = 1'b1
) (
    input  qs_state_e              cur,
    input  logic [SEL_W-1:0]       sel,
    output qs_state_e              nxt
);

    generate
        if (USE_SOP) begin : g_sop
            logic q1, q0, i1, i0;
            logic d1, d0;

            assign q1 = cur[1];
            assign q0 = cur[0];
            assign i1 = sel[1];
            assign i0 = sel[0];

            // flip-flop 1 data input, one product term per group of minterms
            assign d1 = (~q1 & ~q0 &  i1)
                      | (~q1 &  q0 &  i0)
                      | ( q1 & ~q0 & ~i1 &  i0)
                      | ( q1 & ~q0 &  i1 & ~i0)
                      | ( q1 &  q0 &  i1 &  i0);

            // flip-flop 0 data input
            assign d0 = (~q1 & ~q0 &  i0)
                      | (~q1 &  q0 &  i1)
                      | (~q1 &  q0 &  i0)
                      | ( q1 & ~q0 & ~i1)
                      | ( q1 &  q0 & ~i1 & ~i0)
                      | ( q1 &  q0 &  i1 &  i0);

            assign nxt = qs_state_e'({d1, d0});
        end else begin : g_case
            always_comb begin
                nxt = ST_A;
                unique case (cur)
                    ST_A: nxt = qs_state_e'(sel);
                    ST_B: begin
                        unique case (sel)
                            2'b00:   nxt = ST_A;
                            2'b10:   nxt = ST_B;
                            default: nxt = ST_D;
                        endcase
                    end
                    ST_C: begin
                        unique case (sel)
                            2'b00:   nxt = ST_B;
                            2'b01:   nxt = ST_D;
                            2'b10:   nxt = ST_C;
                            default: nxt = ST_A;
                        endcase
                    end
                    ST_D: begin
                        unique case (sel)
                            2'b00:   nxt = ST_B;
                            2'b11:   nxt = ST_D;
                            default: nxt = ST_A;
                        endcase
                    end
                    default: nxt = ST_A;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/quad_seq_reg.sv
module quad_seq_reg
    import quad_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  qs_state_e d,
    output qs_state_e q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ST_A;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/quad_seq_out.sv
module quad_seq_out
    import quad_seq_pkg::*;
(
    input  qs_state_e cur,
    output logic      flag
);

    always_comb begin
        flag = 1'b0;
        unique case (cur)
            ST_A:    flag = 1'b1;
            ST_B:    flag = 1'b0;
            ST_C:    flag = 1'b1;
            ST_D:    flag = 1'b0;
            default: flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/quad_seq.sv
module quad_seq
    import quad_seq_pkg::*;
#(
    parameter bit USE_SOP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             flag_o,
    output logic [ST_W-1:0]  state_o
);

    qs_state_e cur_st;
    qs_state_e nxt_st;

    quad_seq_next #(.USE_SOP(USE_SOP)) u_next (
        .cur (cur_st),
        .sel (sel),
        .nxt (nxt_st)
    );

    quad_seq_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt_st),
        .q   (cur_st)
    );

    quad_seq_out u_out (
        .cur  (cur_st),
        .flag (flag_o)
    );

    assign state_o = cur_st;

endmodule

// File: rtl/quad_seq_chk.sv
module quad_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sel,
    input logic [1:0] state,
    input logic       flag
);

    // R1 and R7: reset wins over the selector
    a_r1_reset_to_a: assert property (@(posedge clk) rst |=> (state == 2'b00));

    // R2: from ST_A the selector value is the next state code
    a_r2_from_a: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00) |=> (state == $past(sel)));

    // R3
    a_r3_from_b_00: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 && sel == 2'b00) |=> (state == 2'b00));
    a_r3_from_b_10: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 && sel == 2'b10) |=> (state == 2'b01));
    a_r3_from_b_x1: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 && sel[0]) |=> (state == 2'b11));

    // R4
    a_r4_from_c_00: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && sel == 2'b00) |=> (state == 2'b01));
    a_r4_from_c_01: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && sel == 2'b01) |=> (state == 2'b11));
    a_r4_from_c_10: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && sel == 2'b10) |=> (state == 2'b10));
    a_r4_from_c_11: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && sel == 2'b11) |=> (state == 2'b00));

    // R5
    a_r5_from_d_00: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && sel == 2'b00) |=> (state == 2'b01));
    a_r5_from_d_mix: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && (sel == 2'b01 || sel == 2'b10)) |=> (state == 2'b00));
    a_r5_from_d_11: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && sel == 2'b11) |=> (state == 2'b11));

    // R6: the flag follows the state, never the selector
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        flag |-> (state == 2'b00 || state == 2'b10));
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
        !flag |-> (state == 2'b01 || state == 2'b11));
    a_r6_flag_steady: assert property (@(posedge clk) disable iff (rst)
        $stable(state) |-> $stable(flag));

endmodule

bind quad_seq quad_seq_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .state (state_o),
    .flag  (flag_o)
);

// File: tb/quad_seq_bench.sv
`timescale 1ns/1ps
module quad_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       flag_o;
    logic [1:0] state_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    quad_seq u_quad_seq (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .flag_o  (flag_o),
        .state_o (state_o)
    );

    function automatic logic [1:0] exp_next(input logic [1:0] s, input logic [1:0] i);
        case (s)
            2'b00: return i;
            2'b01: case (i) 2'b00: return 2'b00; 2'b01: return 2'b11;
                            2'b10: return 2'b01; default: return 2'b11; endcase
            2'b10: case (i) 2'b00: return 2'b01; 2'b01: return 2'b11;
                            2'b10: return 2'b10; default: return 2'b00; endcase
            default: case (i) 2'b00: return 2'b01; 2'b11: return 2'b11;
                              default: return 2'b00; endcase
        endcase
    endfunction

    function automatic logic exp_flag(input logic [1:0] s);
        return (s == 2'b00) || (s == 2'b10);
    endfunction

    function automatic string tag_for(input logic [1:0] s);
        case (s)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        sel = 2'b11;
        @(posedge clk);
        @(negedge clk);
        check(state_o == 2'b00, "R1", state_o, 0);
        check(flag_o == 1'b1, "R1", flag_o, 1);
    endtask

    // R7: selector ignored while reset is held
    task automatic t_reset_hold();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            sel = 2'(i);
            @(posedge clk);
            @(negedge clk);
            check(state_o == 2'b00, "R7", state_o, 0);
        end
    endtask

    // R2..R6: one state/selector pair
    task automatic t_cell(input logic [1:0] s, input logic [1:0] i);
        logic [1:0] e;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sel = s;
        @(posedge clk);
        @(negedge clk);
        check(state_o == s, "R2", state_o, s);
        check(flag_o == exp_flag(s), "R6", flag_o, exp_flag(s));
        sel = i;
        #1;
        check(flag_o == exp_flag(s), "R6", flag_o, exp_flag(s));
        e = exp_next(s, i);
        @(posedge clk);
        @(negedge clk);
        check(state_o == e, tag_for(s), state_o, e);
        check(flag_o == exp_flag(e), "R6", flag_o, exp_flag(e));
    endtask

    // R3/R4/R5: a longer walk through the table without reset
    task automatic t_walk();
        logic [1:0] s;
        logic [1:0] seq [8] = '{2'b01, 2'b10, 2'b01, 2'b00, 2'b10, 2'b11, 2'b01, 2'b00};
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        s = 2'b00;
        for (int k = 0; k < 8; k++) begin
            sel = seq[k];
            @(posedge clk);
            @(negedge clk);
            s = exp_next(s, seq[k]);
            check(state_o == s, tag_for(s), state_o, s);
        end
    endtask

    initial begin
        t_reset();
        t_reset_hold();
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 4; i++) begin
                t_cell(2'(s), 2'(i));
            end
        end
        t_walk();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule